// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block keeps the pending state of the private interrupts that belong to one processor: a set of software-generated interrupts (default 16, vector bits 0 to 15) and a set of peripheral interrupts driven by per-line level inputs (default 16, vector bits 16 to 31). Each peripheral line is either edge-latched or level-sensitive, chosen by a per-line configuration bit. A level-sensitive line never writes the pending latch. It appears only in the effective pending vector, which is the latch ORed with the stored line level.

A software-generated request carries a target number, the group it asks for and a non-secure flag. A security filter checks it before anything is latched. A request that is turned down is dropped without any trace. The register bank next to the block also sends set and clear masks that act on the latch directly. The outputs are the latch vector, the effective vector and a one-cycle strobe that tells the priority logic downstream to re-evaluate. All three are registered and change on the clock edge that samples the stimulus.

Top module: `pirq_pend_tracker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pend`, `eff_pend` and `upd` are all zero, and the stored line levels are zero.
- R2: When an edge-configured peripheral line n (`edge_cfg[n]`=1) is sampled high and its stored level is low, `pend[16+n]` is 1 after that clock edge.
- R3: A level-configured peripheral line (`edge_cfg[n]`=0) never sets `pend[16+n]`. After each edge, `eff_pend[16+n]` equals `pend[16+n]` ORed with the line level sampled at that edge.
- R4: A peripheral line whose sampled level equals its stored level causes no action. An edge line that is held high after its pending bit was cleared does not set the bit again.
- R5: A request for group 1 (`sgi_g1`=1) to a target configured as group 0 (`grp_cfg[id]`=0) is treated as a group 0 request. For a secure request it is accepted.
- R6: A group 0 request to a target configured as group 1 is dropped, and `pend[id]` is unchanged.
- R7: When `sec_en`=1 and `sgi_ns`=1, the 2-bit field `nsac[2*id+1:2*id]` must be at least 1 for a group 0 target and at least 2 for a group 1 target, or else the request is dropped. The field is not checked for secure requests or when `sec_en`=0.
- R8: An accepted request sets `pend[id]` after the clock edge that samples it.
- R9: `sw_set` and `sw_clr` act on the latch at the same edge. When a hardware set (R2 or R8) and `sw_clr` hit the same bit, the set wins.
- R10: `upd` is 1 for exactly the cycles in which `pend` or `eff_pend` differs from its value in the previous cycle.
- R11: For software-generated interrupts and for edge-configured lines, `eff_pend` equals `pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_en | input | 1 | Security is enabled, so non-secure requests need access rights |
| grp_cfg | input | 32 | Configured group per interrupt, 1 = group 1 |
| edge_cfg | input | 16 | Per peripheral line, 1 = edge-latched, 0 = level-sensitive |
| nsac | input | 32 | Non-secure access level, 2 bits per software interrupt |
| ppi_level | input | 16 | Peripheral interrupt line levels |
| sgi_req | input | 1 | Software-generated request is valid this cycle |
| sgi_id | input | 4 | Target software interrupt number |
| sgi_g1 | input | 1 | Request asks for group 1 |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| sw_set | input | 32 | Set-pending mask from the register bank |
| sw_clr | input | 32 | Clear-pending mask from the register bank |
| pend | output | 32 | Pending latch vector |
| eff_pend | output | 32 | Pending latch ORed with the level-sensitive line levels |
| upd | output | 1 | One-cycle strobe when either vector changes |

## Verification
Every state element reaches a port in the cycle right after it changes. A wrong latch bit shows in `pend` at once. A wrong stored line level shows either as a missing or spurious edge set on the next transition, or directly in `eff_pend` for a level line. A filter mistake shows as a `pend[id]` bit that rises when it should not, or that fails to rise, one edge after the request. A missed or extra `upd` pulse can be seen in the same cycle as the vector change it should mark.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Non-secure access level held in each 2-bit field; the ordering is used
  // as a threshold: group 0 targets need G0 or more, group 1 needs G01.
  typedef enum logic [1:0] {
    NSA_NONE = 2'd0,
    NSA_G0   = 2'd1,
    NSA_G01  = 2'd2,
    NSA_ALL  = 2'd3
  } ns_acc_e;

  // Group encoding of a configuration bit.
  localparam logic GRP0 = 1'b0;
  localparam logic GRP1 = 1'b1;

endpackage

// File: rtl/pirq_sgi_gate.sv
module pirq_sgi_gate #(
  parameter int NUM_SGI = 16,
  parameter int ACC_W   = 2,
  localparam int IDW    = $clog2(NUM_SGI)
) (
  input  logic                     req_vld,
  input  logic [IDW-1:0]           req_id,
  input  logic                     req_g1,
  input  logic                     req_ns,
  input  logic                     sec_en,
  input  logic [NUM_SGI-1:0]       grp_cfg,
  input  logic [NUM_SGI*ACC_W-1:0] nsac,
  output logic [NUM_SGI-1:0]       set_vec
);
  import pirq_pkg::*;

  // One small filter per target; only the addressed one can fire.
  for (genvar i = 0; i < NUM_SGI; i++) begin : g_tgt
    logic             hit;
    logic             cfg_g;
    logic             eff_g;
    logic             grp_ok;
    logic [ACC_W-1:0] acc;
    logic             acc_ok;

    always_comb begin
      hit   = req_vld && (req_id == IDW'(i));
      cfg_g = grp_cfg[i];
      // A group 1 request toward a group 0 target is demoted to group 0.
      eff_g = (req_g1 && cfg_g == GRP0) ? GRP0 : req_g1;
      grp_ok = (eff_g == cfg_g);
      acc   = nsac[i*ACC_W +: ACC_W];
      if (req_ns && sec_en) begin
        if (cfg_g == GRP1) acc_ok = (acc >= ACC_W'(NSA_G01));
        else               acc_ok = (acc >= ACC_W'(NSA_G0));
      end else begin
        acc_ok = 1'b1;
      end
      set_vec[i] = hit && grp_ok && acc_ok;
    end
  end

endmodule

// File: rtl/pirq_line_sense.sv
module pirq_line_sense #(
  parameter int NUM_PPI = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PPI-1:0] line_in,
  input  logic [NUM_PPI-1:0] edge_cfg,
  output logic [NUM_PPI-1:0] lvl_next,
  output logic [NUM_PPI-1:0] edge_set
);

  logic [NUM_PPI-1:0] lvl_q;

  for (genvar i = 0; i < NUM_PPI; i++) begin : g_line
    logic changed;

    always_comb begin
      changed     = (line_in[i] != lvl_q[i]);
      lvl_next[i] = changed ? line_in[i] : lvl_q[i];
      // Only a rising change on an edge-configured line latches.
      edge_set[i] = changed && line_in[i] && edge_cfg[i];
    end

    always_ff @(posedge clk) begin
      if (rst)          lvl_q[i] <= 1'b0;
      else if (changed) lvl_q[i] <= line_in[i];
    end
  end

endmodule

// File: rtl/pirq_latch_bank.sv
module pirq_latch_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hw_set,
  input  logic [WIDTH-1:0] sw_set,
  input  logic [WIDTH-1:0] sw_clr,
  input  logic [WIDTH-1:0] lvl_view,
  output logic [WIDTH-1:0] pend_q,
  output logic [WIDTH-1:0] eff_q,
  output logic             upd_q
);

  logic [WIDTH-1:0] pend_n;
  logic [WIDTH-1:0] eff_n;

  always_comb begin
    // Clear first, then software set, then hardware set on top.
    pend_n = ((pend_q & ~sw_clr) | sw_set) | hw_set;
    eff_n  = pend_n | lvl_view;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      eff_q  <= '0;
      upd_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      eff_q  <= eff_n;
      upd_q  <= (pend_n != pend_q) || (eff_n != eff_q);
    end
  end

endmodule

// File: rtl/pirq_pend_tracker.sv
module pirq_pend_tracker #(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int ACC_W   = 2,
  localparam int TOTAL  = NUM_SGI + NUM_PPI,
  localparam int IDW    = $clog2(NUM_SGI)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sec_en,
  input  logic [TOTAL-1:0]         grp_cfg,
  input  logic [NUM_PPI-1:0]       edge_cfg,
  input  logic [NUM_SGI*ACC_W-1:0] nsac,
  input  logic [NUM_PPI-1:0]       ppi_level,
  input  logic                     sgi_req,
  input  logic [IDW-1:0]           sgi_id,
  input  logic                     sgi_g1,
  input  logic                     sgi_ns,
  input  logic [TOTAL-1:0]         sw_set,
  input  logic [TOTAL-1:0]         sw_clr,
  output logic [TOTAL-1:0]         pend,
  output logic [TOTAL-1:0]         eff_pend,
  output logic                     upd
);

  logic [NUM_SGI-1:0] sgi_set;
  logic [NUM_PPI-1:0] lvl_next;
  logic [NUM_PPI-1:0] ppi_set;
  logic [TOTAL-1:0]   hw_set;
  logic [TOTAL-1:0]   lvl_view;

  pirq_sgi_gate #(
    .NUM_SGI (NUM_SGI),
    .ACC_W   (ACC_W)
  ) u_gate (
    .req_vld (sgi_req),
    .req_id  (sgi_id),
    .req_g1  (sgi_g1),
    .req_ns  (sgi_ns),
    .sec_en  (sec_en),
    .grp_cfg (grp_cfg[NUM_SGI-1:0]),
    .nsac    (nsac),
    .set_vec (sgi_set)
  );

  pirq_line_sense #(
    .NUM_PPI (NUM_PPI)
  ) u_sense (
    .clk      (clk),
    .rst      (rst),
    .line_in  (ppi_level),
    .edge_cfg (edge_cfg),
    .lvl_next (lvl_next),
    .edge_set (ppi_set)
  );

  always_comb begin
    hw_set   = {ppi_set, sgi_set};
    lvl_view = {lvl_next & ~edge_cfg, {NUM_SGI{1'b0}}};
  end

  pirq_latch_bank #(
    .WIDTH (TOTAL)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .hw_set   (hw_set),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .lvl_view (lvl_view),
    .pend_q   (pend),
    .eff_q    (eff_pend),
    .upd_q    (upd)
  );

endmodule

// File: rtl/pirq_pend_tracker_chk.sv
module pirq_pend_tracker_chk #(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  localparam int TOTAL  = NUM_SGI + NUM_PPI,
  localparam int IDW    = $clog2(NUM_SGI)
) (
  input logic               clk,
  input logic               rst,
  input logic [TOTAL-1:0]   grp_cfg,
  input logic [NUM_PPI-1:0] edge_cfg,
  input logic               sgi_req,
  input logic [IDW-1:0]     sgi_id,
  input logic               sgi_g1,
  input logic               sgi_ns,
  input logic [TOTAL-1:0]   sw_set,
  input logic [TOTAL-1:0]   sw_clr,
  input logic [TOTAL-1:0]   pend,
  input logic [TOTAL-1:0]   eff_pend,
  input logic               upd
);

  logic           armed;
  logic           acc_q;
  logic           mis_q;
  logic           bit_q;
  logic [IDW-1:0] id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      acc_q <= 1'b0;
      mis_q <= 1'b0;
      bit_q <= 1'b0;
      id_q  <= '0;
    end else begin
      armed <= 1'b1;
      acc_q <= sgi_req && !sgi_ns && (!grp_cfg[sgi_id] || sgi_g1);
      mis_q <= sgi_req && !sgi_g1 && grp_cfg[sgi_id]
               && !sw_set[sgi_id] && !sw_clr[sgi_id];
      bit_q <= pend[sgi_id];
      id_q  <= sgi_id;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (pend == '0 && eff_pend == '0 && !upd)); // R1

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((pend & ~$past(pend) & ~$past(sw_set)
               & {~$past(edge_cfg), {NUM_SGI{1'b0}}}) == '0)); // R3

  AST_MISMATCH_DROP: assert property (@(posedge clk) disable iff (rst)
    mis_q |-> (pend[id_q] == bit_q)); // R6

  AST_SECURE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> pend[id_q]); // R8

  AST_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((~pend & $past(pend) & ~$past(sw_clr)) == '0)); // R9

  AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (upd == ((pend != $past(pend)) || (eff_pend != $past(eff_pend))))); // R10

  AST_SGI_EFF_EQ: assert property (@(posedge clk) disable iff (rst)
    armed |-> (eff_pend[NUM_SGI-1:0] == pend[NUM_SGI-1:0])); // R11

endmodule

bind pirq_pend_tracker pirq_pend_tracker_chk #(
  .NUM_SGI (NUM_SGI),
  .NUM_PPI (NUM_PPI)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .grp_cfg  (grp_cfg),
  .edge_cfg (edge_cfg),
  .sgi_req  (sgi_req),
  .sgi_id   (sgi_id),
  .sgi_g1   (sgi_g1),
  .sgi_ns   (sgi_ns),
  .sw_set   (sw_set),
  .sw_clr   (sw_clr),
  .pend     (pend),
  .eff_pend (eff_pend),
  .upd      (upd)
);

// File: tb/pirq_pend_tracker_bench.sv
`timescale 1ns/1ps
module pirq_pend_tracker_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        sec_en;
  logic [31:0] grp_cfg;
  logic [15:0] edge_cfg;
  logic [31:0] nsac;
  logic [15:0] ppi_level;
  logic        sgi_req;
  logic [3:0]  sgi_id;
  logic        sgi_g1;
  logic        sgi_ns;
  logic [31:0] sw_set;
  logic [31:0] sw_clr;
  logic [31:0] pend;
  logic [31:0] eff_pend;
  logic        upd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_pend = '0;
  logic [31:0] m_eff  = '0;
  logic [15:0] m_lvl  = '0;
  logic        m_upd  = 1'b0;

  always #2 clk = ~clk;

  pirq_pend_tracker u_pirq_pend_tracker (
    .clk (clk), .rst (rst), .sec_en (sec_en), .grp_cfg (grp_cfg),
    .edge_cfg (edge_cfg), .nsac (nsac), .ppi_level (ppi_level),
    .sgi_req (sgi_req), .sgi_id (sgi_id), .sgi_g1 (sgi_g1), .sgi_ns (sgi_ns),
    .sw_set (sw_set), .sw_clr (sw_clr),
    .pend (pend), .eff_pend (eff_pend), .upd (upd)
  );

  // Acceptance rule written from R5, R6 and R7.
  function automatic bit accept(input logic [3:0] id, input bit g1, input bit ns);
    bit tgt = grp_cfg[id];
    bit rq  = g1;
    int f   = nsac[id*2 +: 2];
    if (rq && !tgt) rq = 1'b0;
    if (rq != tgt) return 1'b0;
    if (ns && sec_en) begin
      if (tgt && f < 2) return 1'b0;
      if (!tgt && f < 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    sgi_req = 0; sgi_id = 0; sgi_g1 = 0; sgi_ns = 0;
    sw_set = '0; sw_clr = '0;
  endtask

  // One clock: update the model from the sampled inputs, compare at negedge.
  task automatic step(input string tag);
    logic [31:0] hw, np, ne;
    @(posedge clk);
    hw = '0;
    if (sgi_req && accept(sgi_id, sgi_g1, sgi_ns)) hw[sgi_id] = 1'b1;
    for (int k = 0; k < 16; k++)
      if (ppi_level[k] && !m_lvl[k] && edge_cfg[k]) hw[16+k] = 1'b1;
    m_lvl = ppi_level;
    np = ((m_pend & ~sw_clr) | sw_set) | hw;
    ne = np | {m_lvl & ~edge_cfg, 16'h0};
    m_upd  = (np != m_pend) || (ne != m_eff);
    m_pend = np;
    m_eff  = ne;
    @(negedge clk);
    check({tag, " pend"}, pend, m_pend);
    check({tag, " eff_pend"}, eff_pend, m_eff);
    check({tag, " upd"}, {31'b0, upd}, {31'b0, m_upd});
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1; sec_en = 0; grp_cfg = '0; edge_cfg = '0; nsac = '0; ppi_level = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R1 pend in reset", pend, '0);
    check("R1 eff in reset", eff_pend, '0);
    check("R1 upd in reset", {31'b0, upd}, '0);
    rst = 0;
    step("R1 first cycle");

    // R2: edge line 3 rising
    edge_cfg = 16'h0008; ppi_level[3] = 1;
    step("R2 edge rise");
    check("R2 pend bit 19", {31'b0, pend[19]}, 32'd1);
    check("R10 upd on edge", {31'b0, upd}, 32'd1);
    // R4: clear, then line held high must not re-set
    idle_inputs(); sw_clr[19] = 1;
    step("R4 clear");
    idle_inputs();
    step("R4 held high");
    check("R4 no re-set", {31'b0, pend[19]}, 32'd0);
    step("R10 quiet cycle");
    check("R10 no upd", {31'b0, upd}, 32'd0);

    // R3: level line 5
    ppi_level[5] = 1;
    step("R3 level high");
    check("R3 no latch", {31'b0, pend[21]}, 32'd0);
    check("R3 eff follows", {31'b0, eff_pend[21]}, 32'd1);
    ppi_level[5] = 0;
    step("R3 level low");
    check("R3 eff drops", {31'b0, eff_pend[21]}, 32'd0);

    // R5: group 1 request to group 0 target
    sgi_req = 1; sgi_id = 2; sgi_g1 = 1;
    step("R5 demote");
    check("R5 accepted", {31'b0, pend[2]}, 32'd1);
    // R6: group 0 request to group 1 target
    grp_cfg[4] = 1; sgi_id = 4; sgi_g1 = 0;
    step("R6 mismatch");
    check("R6 dropped", {31'b0, pend[4]}, 32'd0);

    // R7: non-secure access levels
    sec_en = 1; sgi_ns = 1;
    grp_cfg[6] = 1; nsac[13:12] = 2'd1; sgi_id = 6; sgi_g1 = 1;
    step("R7 g1 low access");
    check("R7 g1 field 1 dropped", {31'b0, pend[6]}, 32'd0);
    nsac[13:12] = 2'd2;
    step("R7 g1 access 2");
    check("R8 g1 field 2 set", {31'b0, pend[6]}, 32'd1);
    sgi_id = 7; sgi_g1 = 0; nsac[15:14] = 2'd0;
    step("R7 g0 access 0");
    check("R7 g0 field 0 dropped", {31'b0, pend[7]}, 32'd0);
    nsac[15:14] = 2'd1;
    step("R7 g0 access 1");
    check("R8 g0 field 1 set", {31'b0, pend[7]}, 32'd1);

    // R9: hardware set beats clear; software set
    sgi_ns = 0; sgi_id = 8; sgi_g1 = 0; sw_clr[8] = 1; sw_set[9] = 1;
    step("R9 set vs clear");
    check("R9 hw wins", {31'b0, pend[8]}, 32'd1);
    check("R9 sw set", {31'b0, pend[9]}, 32'd1);
    idle_inputs();

    // Random phase
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (cyc % 100 == 0) begin
        grp_cfg  = $urandom;
        edge_cfg = 16'($urandom);
        nsac     = $urandom;
        sec_en   = 1'($urandom);
      end
      ppi_level = ppi_level ^ (16'($urandom) & 16'($urandom));
      sgi_req = 1'($urandom);
      sgi_id  = 4'($urandom);
      sgi_g1  = 1'($urandom);
      sgi_ns  = 1'($urandom);
      sw_set  = $urandom & $urandom & $urandom;
      sw_clr  = $urandom & $urandom;
      step("R2 R3 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule